// File: doc/BRIEF.md
# Network Controller Interrupt Status Word

This block holds the sixteen-bit interrupt status word of a network controller. The upper byte has eight sticky event flags. The command engine, the receive engine, a management-data engine, software and the flow-control logic each raise one of them. A flag stays set until software clears it over a simple register bus by writing a one to its bit position. Two read-only bits in the lower byte report the current state of the command engine. The other six lower bits read as zero.

The command-engine not-active flag is not driven by a direct event input. The block watches the command engine's state code and sets the flag when the state changes. A mode input selects the condition. In the first mode, any move out of an active queue into Idle or Suspended sets the flag. In the second mode, only an entry into Idle sets it. One interrupt output is asserted while any event flag is set.

Top module: `isw_status`

## Requirements
- R1: After reset the status word reads 0x0000 (with the command state input at Idle) and `irq` is low.
- R2: Each event input sets its own flag at the next clock edge. The flag positions are: bit 15 command executed, bit 14 frame received, bit 13 command engine not active, bit 12 receive not ready, bit 11 management cycle done, bit 10 software request, bit 9 early receive, bit 8 flow-control pause.
- R3: A bus write clears each flag in bits 15:8 whose data bit is 1. A data bit of 0 leaves its flag unchanged, and a flag with no write stays set.
- R4: If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Bits 7:6 always show the live command state code: 00 Idle, 01 Suspended, 10 low-priority queue active, 11 high-priority queue active. Bits 5:0 read as zero. Writes to bits 7:0 have no effect.
- R6: With `cna_mode` = 1, bit 13 sets when the state moves from 10 or 11 to 00 or 01. No other move sets it.
- R7: With `cna_mode` = 0, bit 13 sets when the state changes from any non-Idle code to 00. No other move sets it.
- R8: Bit 15 sets only when `cu_done` and `cu_irq_req` are high in the same cycle.
- R9: Bit 11 sets only when `mgmt_done` and `mgmt_irq_en` are high in the same cycle.
- R10: `irq` equals the OR of bits 15:8 of the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe for the status word |
| wr_data | input | 16 | Write data; a 1 in bits 15:8 clears that flag |
| rd_data | output | 16 | Current status word, combinational |
| irq | output | 1 | Interrupt request, high while any flag is set |
| cu_state | input | 2 | Command engine state code |
| cna_mode | input | 1 | 1: set bit 13 on leaving an active queue; 0: set it on entering Idle |
| cu_done | input | 1 | Command completed, one-cycle pulse |
| cu_irq_req | input | 1 | Completed command asked for an interrupt |
| rx_frame_done | input | 1 | Receive engine finished a frame |
| ru_not_ready | input | 1 | Receive engine left its Ready state |
| mgmt_done | input | 1 | Management data cycle finished |
| mgmt_irq_en | input | 1 | Enables the management-done flag |
| sw_req | input | 1 | Software interrupt request |
| early_rx | input | 1 | Early receive indication |
| fc_pause | input | 1 | Flow-control pause indication |

## Verification
The transition assertions compare the state code with its value one cycle earlier. They therefore assume that the command state input is Idle while reset is applied, which matches the reset value of the internal previous-state register. The bench holds `cu_state` at 00 during reset. After reset it changes inputs only on the falling clock edge, so each change is seen at exactly one rising edge. Event inputs are driven as single-cycle pulses and are returned to zero before any result is sampled.

// File: rtl/isw_pkg.sv
package isw_pkg;

  typedef enum logic [1:0] {
    CU_IDLE = 2'b00,
    CU_SUSP = 2'b01,
    CU_LPQ  = 2'b10,
    CU_HPQ  = 2'b11
  } cu_state_e;

  // Flag positions, relative to the low bit of the flag byte
  localparam int EV_CMD_DONE = 7;
  localparam int EV_FRAME    = 6;
  localparam int EV_NOTACT   = 5;
  localparam int EV_RNR      = 4;
  localparam int EV_MDI      = 3;
  localparam int EV_SWI      = 2;
  localparam int EV_EARLY    = 1;
  localparam int EV_PAUSE    = 0;

  function automatic logic cu_is_active(input cu_state_e s);
    return (s == CU_LPQ) || (s == CU_HPQ);
  endfunction

  // Decides whether a state change raises the not-active flag.
  // leave_mode = 1: an active queue gave way to Idle or Suspended.
  // leave_mode = 0: Idle was entered from any other state.
  function automatic logic notact_hit(input logic leave_mode,
                                      input cu_state_e prev,
                                      input cu_state_e cur);
    if (leave_mode)
      return cu_is_active(prev) && !cu_is_active(cur);
    else
      return (prev != CU_IDLE) && (cur == CU_IDLE);
  endfunction

endpackage

// File: rtl/isw_cu_watch.sv
module isw_cu_watch
  import isw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cna_mode,
  input  cu_state_e cu_state,
  output logic      notact_ev
);

  cu_state_e prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= CU_IDLE;
    else        prev_q <= cu_state;
  end

  always_comb notact_ev = notact_hit(cna_mode, prev_q, cu_state);

endmodule

// File: rtl/isw_flag_bank.sv
module isw_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags,
  output logic         any_set
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;  // an event takes priority over a clear
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end

  always_comb any_set = |flags;

endmodule

// File: rtl/isw_status.sv
module isw_status
  import isw_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int FLAG_W    = 8,
  parameter int FLAG_LSB  = 8,
  parameter int STATE_LSB = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  input  logic [1:0]        cu_state,
  input  logic              cna_mode,
  input  logic              cu_done,
  input  logic              cu_irq_req,
  input  logic              rx_frame_done,
  input  logic              ru_not_ready,
  input  logic              mgmt_done,
  input  logic              mgmt_irq_en,
  input  logic              sw_req,
  input  logic              early_rx,
  input  logic              fc_pause
);

  localparam int STATE_W = 2;

  cu_state_e          cu_st;
  logic               notact_ev;
  logic [FLAG_W-1:0]  set_vec;
  logic [FLAG_W-1:0]  clr_vec;
  logic [FLAG_W-1:0]  flags;

  assign cu_st = cu_state_e'(cu_state);

  isw_cu_watch u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cna_mode  (cna_mode),
    .cu_state  (cu_st),
    .notact_ev (notact_ev)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[EV_CMD_DONE] = cu_done & cu_irq_req;
    set_vec[EV_FRAME]    = rx_frame_done;
    set_vec[EV_NOTACT]   = notact_ev;
    set_vec[EV_RNR]      = ru_not_ready;
    set_vec[EV_MDI]      = mgmt_done & mgmt_irq_en;
    set_vec[EV_SWI]      = sw_req;
    set_vec[EV_EARLY]    = early_rx;
    set_vec[EV_PAUSE]    = fc_pause;
  end

  assign clr_vec = wr_en ? wr_data[FLAG_LSB +: FLAG_W] : '0;

  isw_flag_bank #(.N(FLAG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags),
    .any_set (irq)
  );

  always_comb begin
    rd_data                         = '0;
    rd_data[FLAG_LSB +: FLAG_W]     = flags;
    rd_data[STATE_LSB +: STATE_W]   = cu_state;
  end

endmodule

// File: rtl/isw_status_chk.sv
module isw_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        irq,
  input logic [1:0]  cu_state,
  input logic        cna_mode,
  input logic        cu_done,
  input logic        cu_irq_req,
  input logic        mgmt_done,
  input logic        mgmt_irq_en,
  input logic [7:0]  set_vec,
  input logic [7:0]  flags
);

  // R10: interrupt output follows the flag byte
  a_r10_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|rd_data[15:8]));

  // R3: a flag with no event and no write keeps its value
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((flags & $past(flags)) == $past(flags)));

  // R3: a written 1 without a competing event clears the flag
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data[15:8] & $past(wr_data[15:8] & ~set_vec)) == 8'h00));

  // R4: every event lands, whatever the bus does
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((rd_data[15:8] & $past(set_vec)) == $past(set_vec)));

  // R5: low byte holds the live state code and zeros, and writes to it change nothing
  a_r5_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[7:0] != 8'h00)) |=> (rd_data[7:0] == {cu_state, 6'b0}));

  // R8: command-executed flag needs the interrupt request
  a_r8_cmd_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[15]) |-> $past(cu_done && cu_irq_req));

  // R9: management flag needs its enable
  a_r9_mdi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[11]) |-> $past(mgmt_done && mgmt_irq_en));

  // R6: leaving an active queue sets the not-active flag
  a_r6_leave_active: assert property (@(posedge clk) disable iff (!rst_n)
    (cna_mode && $past(cu_state[1]) && !cu_state[1]) |=> rd_data[13]);

  // R7: entering Idle sets the not-active flag
  a_r7_enter_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cna_mode && ($past(cu_state) != 2'b00) && (cu_state == 2'b00)) |=> rd_data[13]);

endmodule

bind isw_status isw_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .irq         (irq),
  .cu_state    (cu_state),
  .cna_mode    (cna_mode),
  .cu_done     (cu_done),
  .cu_irq_req  (cu_irq_req),
  .mgmt_done   (mgmt_done),
  .mgmt_irq_en (mgmt_irq_en),
  .set_vec     (set_vec),
  .flags       (flags)
);

// File: tb/sim_isw_status.sv
module sim_isw_status;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;
  logic [1:0]  cu_state = 2'b00;
  logic        cna_mode = 1'b1;
  logic        cu_done = 1'b0, cu_irq_req = 1'b0, rx_frame_done = 1'b0;
  logic        ru_not_ready = 1'b0, mgmt_done = 1'b0, mgmt_irq_en = 1'b0;
  logic        sw_req = 1'b0, early_rx = 1'b0, fc_pause = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  isw_status u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .cu_state(cu_state), .cna_mode(cna_mode),
    .cu_done(cu_done), .cu_irq_req(cu_irq_req), .rx_frame_done(rx_frame_done),
    .ru_not_ready(ru_not_ready), .mgmt_done(mgmt_done), .mgmt_irq_en(mgmt_irq_en),
    .sw_req(sw_req), .early_rx(early_rx), .fc_pause(fc_pause)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drop_events;
    cu_done = 0; cu_irq_req = 0; rx_frame_done = 0; ru_not_ready = 0;
    mgmt_done = 0; mgmt_irq_en = 0; sw_req = 0; early_rx = 0; fc_pause = 0;
    wr_en = 0; wr_data = '0;
  endtask

  task automatic bus_write(input logic [15:0] d);
    wr_en = 1; wr_data = d;
    tick;
    wr_en = 0; wr_data = '0;
  endtask

  task automatic raise(input int b);
    case (b)
      15: begin cu_done = 1; cu_irq_req = 1; end
      14: rx_frame_done = 1;
      12: ru_not_ready = 1;
      11: begin mgmt_done = 1; mgmt_irq_en = 1; end
      10: sw_req = 1;
      9:  early_rx = 1;
      default: fc_pause = 1;
    endcase
    tick;
    drop_events;
  endtask

  task automatic move_to(input logic [1:0] s);
    cu_state = s;
    tick;
  endtask

  task automatic t_reset;
    rst_n = 0; cu_state = 2'b00;
    repeat (3) tick;
    rst_n = 1;
    chk("R1 reset word", rd_data, 16'h0000);
    chk("R1 reset irq", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_each_event;
    int bits[7] = '{15, 14, 12, 11, 10, 9, 8};
    foreach (bits[k]) begin
      raise(bits[k]);
      chk($sformatf("R2 event bit %0d", bits[k]), rd_data, 16'h1 << bits[k]);
      chk("R10 irq on one flag", {15'b0, irq}, 16'h0001);
      bus_write(16'hFF00);
      chk("R3 clear all", rd_data, 16'h0000);
    end
  endtask

  task automatic t_partial_clear;
    rx_frame_done = 1; sw_req = 1;
    tick;
    drop_events;
    chk("R2 two flags", rd_data, 16'h4400);
    bus_write(16'h4000);
    chk("R3 clear one keeps other", rd_data, 16'h0400);
    bus_write(16'h0000);
    chk("R3 zero write keeps", rd_data, 16'h0400);
    chk("R10 irq stays while flag set", {15'b0, irq}, 16'h0001);
    bus_write(16'h0400);
    chk("R10 irq drops", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_set_wins;
    raise(14);
    raise(9);
    rx_frame_done = 1; wr_en = 1; wr_data = 16'h4200;
    tick;
    drop_events;
    chk("R4 set beats clear", rd_data, 16'h4000);
    bus_write(16'hFF00);
  endtask

  task automatic t_gates;
    cu_done = 1; cu_irq_req = 0;
    tick;
    drop_events;
    chk("R8 done without request", rd_data, 16'h0000);
    cu_irq_req = 1;
    tick;
    drop_events;
    chk("R8 request without done", rd_data, 16'h0000);
    mgmt_done = 1; mgmt_irq_en = 0;
    tick;
    drop_events;
    chk("R9 mgmt disabled", rd_data, 16'h0000);
  endtask

  task automatic t_state_field;
    cna_mode = 0;
    for (int s = 0; s < 4; s++) begin
      cu_state = 2'(s);
      #1;
      chk($sformatf("R5 state code %0d", s), {8'h00, rd_data[7:0]}, {8'h00, 2'(s), 6'b0});
      tick;
    end
    bus_write(16'h00FF);
    chk("R5 low write ignored", {8'h00, rd_data[7:0]}, 16'h00C0);
    move_to(2'b00);
    bus_write(16'hFF00);
    chk("R5 clean after state walk", rd_data, 16'h0000);
  endtask

  task automatic t_leave_mode;
    cna_mode = 1;
    move_to(2'b10);
    chk("R6 idle to low queue no set", rd_data, 16'h0080);
    move_to(2'b01);
    chk("R6 low queue to suspend sets", rd_data, 16'h2040);
    bus_write(16'h2000);
    move_to(2'b11);
    chk("R6 suspend to high queue no set", rd_data, 16'h00C0);
    move_to(2'b00);
    chk("R6 high queue to idle sets", rd_data, 16'h2000);
    bus_write(16'h2000);
    move_to(2'b01);
    move_to(2'b00);
    chk("R6 suspend and idle moves no set", rd_data, 16'h0000);
  endtask

  task automatic t_enter_idle;
    cna_mode = 0;
    move_to(2'b10);
    move_to(2'b01);
    chk("R7 low queue to suspend no set", rd_data, 16'h0040);
    move_to(2'b00);
    chk("R7 suspend to idle sets", rd_data, 16'h2000);
    bus_write(16'h2000);
    move_to(2'b11);
    move_to(2'b00);
    chk("R7 high queue to idle sets", rd_data, 16'h2000);
    bus_write(16'h2000);
    move_to(2'b00);
    chk("R7 idle held no set", rd_data, 16'h0000);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_each_event;
    t_partial_clear;
    t_set_wins;
    t_gates;
    t_state_field;
    t_leave_mode;
    t_enter_idle;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule